// File: doc/BRIEF.md
# I/O Interrupt Redirection Router

The router watches a set of interrupt input lines and turns them into vector messages. Each line has its own 64-bit redirection entry. The entry gives the vector, a delivery mode, a destination-mode flag, the line polarity, the trigger kind and a mask. An active line sets a request bit. Each clock, the lowest-numbered pin that may be delivered is chosen and sent out as a single-cycle delivery strobe. The strobe carries the pin number and the fields from that pin's entry.

Level-triggered lines need an end-of-interrupt handshake. Delivering a level pin does not clear its request. Instead it sets a read-only "in service" flag (remote IRR) in the entry, and that flag blocks any further delivery of the pin. When an end-of-interrupt broadcast arrives, its vector is compared with every entry whose flag is set, and each match has its flag cleared. If the line is still active and the entry is unmasked, the pin is delivered again. This avoids the lost-interrupt case, where a line held high never raises a second request.

Software reaches the entries through a single-address read/write port. Reads are combinational.

Top module: `intr_redir`

## Requirements
- R1: After reset, every entry reads 0x0000_0000_0001_0000 (mask set, all other fields zero), and no delivery occurs.
- R2: Entry field positions are: vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], remote IRR [14], trigger [15] (1 = level), mask [16]. A delivery carries the vector, mode and destination-mode fields of the delivered pin.
- R3: An edge pin latches a request on an inactive-to-active transition. It is delivered once, and its request is cleared, so holding the line active does not cause a second delivery.
- R4: Delivering a level pin sets its remote IRR (bit 14 reads back as 1). While that bit is set, the pin is not delivered again.
- R5: An end-of-interrupt whose vector matches an entry with remote IRR set clears that bit. If the line is still active and the entry is unmasked, the pin is delivered again.
- R6: An end-of-interrupt has no effect on entries whose remote IRR is clear, even when the vectors match. It also has no effect on entries whose vector differs.
- R7: An end-of-interrupt on a level pin whose line has gone inactive clears remote IRR and produces no delivery.
- R8: A masked pin is never delivered. An edge request latched while the pin is masked is delivered once the mask is cleared.
- R9: When several pins are deliverable, one pin is delivered per clock, in ascending pin order.
- R10: Register writes leave remote IRR unchanged, whatever value bit 14 of the write data holds.
- R11: Polarity 1 makes the line active-low. Polarity 0 makes it active-high.
- R12: A delivery strobe appears at the second rising clock edge after an active transition is first applied before an edge. The first edge latches the request and the second edge delivers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Interrupt input lines |
| reg_addr_i | input | AW | Entry index for read and write |
| reg_we_i | input | 1 | Write strobe for the addressed entry |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Addressed entry, with live remote IRR in bit 14 |
| eoi_i | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector_i | input | 8 | Vector carried by the broadcast |
| dlv_o | output | 1 | Delivery strobe, one cycle |
| dlv_pin_o | output | AW | Pin being delivered |
| dlv_vector_o | output | 8 | Vector of the delivered pin |
| dlv_mode_o | output | 3 | Delivery mode of the delivered pin |
| dlv_dest_o | output | 1 | Destination-mode flag of the delivered pin |
| dlv_level_o | output | 1 | Delivered pin is level-triggered |

## Verification
The assertions check several properties on every cycle:
- remote IRR changes only through a delivery or an end-of-interrupt;
- a broadcast can only clear flags;
- any level delivery leaves its flag set;
- the chosen pin has no deliverable pin below it;
- no delivered pin was masked.

The bench scenarios cover what needs a history of stimulus:
- the redelivery after a matching end-of-interrupt while the line stays active;
- the silent clear when the line has dropped;
- the active-low and latched-while-masked cases;
- the two-edge latency.

A queue-based scoreboard checks the order and the fields of each delivery.

// File: rtl/intr_redir_pkg.sv
package intr_redir_pkg;
  localparam int ENTRY_W  = 64;
  localparam int VEC_W    = 8;
  localparam int VEC_LSB  = 0;
  localparam int MODE_W   = 3;
  localparam int MODE_LSB = 8;
  localparam int DEST_BIT = 11;
  localparam int POL_BIT  = 13;
  localparam int RIRR_BIT = 14;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;

  localparam logic [ENTRY_W-1:0] ENTRY_RST = ENTRY_W'(1) << MASK_BIT;
endpackage

// File: rtl/redir_table.sv
module redir_table
  import intr_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int AW = $clog2(NUM_PINS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [AW-1:0]                     addr_i,
  input  logic [ENTRY_W-1:0]                wdata_i,
  output logic [ENTRY_W-1:0]                rdata_o,
  input  logic                              eoi_i,
  input  logic [VEC_W-1:0]                  eoi_vector_i,
  input  logic                              set_en_i,
  input  logic [AW-1:0]                     set_idx_i,
  output logic [NUM_PINS-1:0][ENTRY_W-1:0]  entries_o,
  output logic [NUM_PINS-1:0]               rirr_o
);
  logic [NUM_PINS-1:0][ENTRY_W-1:0] ent_q;
  logic [NUM_PINS-1:0]              rirr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PINS; i++) ent_q[i] <= ENTRY_RST;
    end else if (we_i) begin
      for (int i = 0; i < NUM_PINS; i++)
        if (addr_i == AW'(i)) ent_q[i] <= wdata_i & ~(ENTRY_W'(1) << RIRR_BIT);
    end
  end

  // a delivery needs rirr clear, an EOI only touches rirr set: never both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rirr_q <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (set_en_i && set_idx_i == AW'(i))
          rirr_q[i] <= 1'b1;
        else if (eoi_i && rirr_q[i] && ent_q[i][VEC_LSB +: VEC_W] == eoi_vector_i)
          rirr_q[i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_merge
    always_comb begin
      entries_o[g]           = ent_q[g];
      entries_o[g][RIRR_BIT] = rirr_q[g];
    end
  end

  assign rirr_o  = rirr_q;
  assign rdata_o = (32'(addr_i) < NUM_PINS) ? entries_o[addr_i] : '0;

  // R10
  rirr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_en_i && !eoi_i) |=> $stable(rirr_q));

  // R6
  eoi_clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !set_en_i) |=> ((rirr_q & ~$past(rirr_q)) == '0));
endmodule

// File: rtl/req_latch.sv
module req_latch #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] irr_o
);
  logic [NUM_PINS-1:0] act, act_q, irr_q;

  assign act = pins_i ^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      irr_q <= '0;
    end else begin
      act_q <= act;
      for (int i = 0; i < NUM_PINS; i++)
        irr_q[i] <= level_i[i] ? act[i]
                  : ((irr_q[i] & ~clr_i[i]) | (act[i] & ~act_q[i]));
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/pick_lowest.sv
module pick_lowest #(
  parameter int N  = 24,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        valid_o = 1'b1;
        idx_o   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/intr_redir.sv
module intr_redir
  import intr_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int AW = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [AW-1:0]       reg_addr_i,
  input  logic                reg_we_i,
  input  logic [63:0]         reg_wdata_i,
  output logic [63:0]         reg_rdata_o,
  input  logic                eoi_i,
  input  logic [7:0]          eoi_vector_i,
  output logic                dlv_o,
  output logic [AW-1:0]       dlv_pin_o,
  output logic [7:0]          dlv_vector_o,
  output logic [2:0]          dlv_mode_o,
  output logic                dlv_dest_o,
  output logic                dlv_level_o
);
  logic [NUM_PINS-1:0][ENTRY_W-1:0] entries;
  logic [NUM_PINS-1:0] rirr_v, mask_v, level_v, pol_v, irr_v, deliverable, clr_v;
  logic                pick_valid, set_en;
  logic [AW-1:0]       pick_idx;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_fields
    assign mask_v[g]  = entries[g][MASK_BIT];
    assign level_v[g] = entries[g][TRIG_BIT];
    assign pol_v[g]   = entries[g][POL_BIT];
  end

  redir_table #(.NUM_PINS(NUM_PINS), .AW(AW)) u_table (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .eoi_i, .eoi_vector_i,
    .set_en_i(set_en), .set_idx_i(pick_idx),
    .entries_o(entries), .rirr_o(rirr_v)
  );

  req_latch #(.NUM_PINS(NUM_PINS)) u_req (
    .clk_i, .rst_ni, .pins_i, .pol_i(pol_v), .level_i(level_v),
    .clr_i(clr_v), .irr_o(irr_v)
  );

  assign deliverable = irr_v & ~mask_v & ~(level_v & rirr_v);

  pick_lowest #(.N(NUM_PINS), .IW(AW)) u_pick (
    .req_i(deliverable), .valid_o(pick_valid), .idx_o(pick_idx)
  );

  assign set_en = pick_valid & level_v[pick_idx];
  assign clr_v  = (pick_valid && !level_v[pick_idx]) ? (NUM_PINS'(1) << pick_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlv_o        <= 1'b0;
      dlv_pin_o    <= '0;
      dlv_vector_o <= '0;
      dlv_mode_o   <= '0;
      dlv_dest_o   <= 1'b0;
      dlv_level_o  <= 1'b0;
    end else begin
      dlv_o <= pick_valid;
      if (pick_valid) begin
        dlv_pin_o    <= pick_idx;
        dlv_vector_o <= entries[pick_idx][VEC_LSB +: VEC_W];
        dlv_mode_o   <= entries[pick_idx][MODE_LSB +: MODE_W];
        dlv_dest_o   <= entries[pick_idx][DEST_BIT];
        dlv_level_o  <= level_v[pick_idx];
      end
    end
  end

  // R4
  level_rirr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_o && dlv_level_o) |-> rirr_v[dlv_pin_o]);

  // R9
  lowest_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_valid |-> ((deliverable & ((NUM_PINS'(1) << pick_idx) - NUM_PINS'(1))) == '0));

  // R8
  masked_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_o |-> !$past(mask_v[pick_idx]));
endmodule

// File: tb/intr_redir_test.sv
module intr_redir_test;
  localparam int NP = 24;
  localparam int AW = $clog2(NP);

  typedef struct packed {
    logic [AW-1:0] pin;
    logic [7:0]    vec;
    logic [2:0]    mode;
    logic          dest;
    logic          lvl;
  } dlv_t;

  logic          clk = 0, rst_n = 0;
  logic [NP-1:0] pins = '0;
  logic [AW-1:0] addr = '0;
  logic          we = 0, eoi = 0;
  logic [63:0]   wdata = '0, rdata;
  logic [7:0]    eoi_vec = '0;
  logic          dlv, dlv_dest, dlv_lvl;
  logic [AW-1:0] dlv_pin;
  logic [7:0]    dlv_vec;
  logic [2:0]    dlv_mode;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_tag = "R1";
  dlv_t  q[$];

  always #10 clk = ~clk;

  intr_redir #(.NUM_PINS(NP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .eoi_i(eoi), .eoi_vector_i(eoi_vec),
    .dlv_o(dlv), .dlv_pin_o(dlv_pin), .dlv_vector_o(dlv_vec),
    .dlv_mode_o(dlv_mode), .dlv_dest_o(dlv_dest), .dlv_level_o(dlv_lvl)
  );

  function automatic logic [63:0] mk(input logic [7:0] v, input logic [2:0] m,
                                     input logic d, p, t, k);
    return 64'(v) | (64'(m) << 8) | (64'(d) << 11) | (64'(p) << 13)
         | (64'(t) << 15) | (64'(k) << 16);
  endfunction

  localparam logic [63:0] RIRR = 64'(1) << 14;

  // monitor: pops expected deliveries in order
  always @(negedge clk) begin
    if (rst_n && !done && dlv) begin
      dlv_t got, e;
      got = '{pin: dlv_pin, vec: dlv_vec, mode: dlv_mode, dest: dlv_dest, lvl: dlv_lvl};
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL %s: unexpected delivery got %h expected none", cur_tag, got);
      end else begin
        e = q.pop_front();
        if (got !== e) begin
          n_fail++;
          $display("FAIL %s: delivery got %h expected %h", cur_tag, got, e);
        end
      end
    end
  end

  task automatic push(input int p, input logic [7:0] v, input logic [2:0] m,
                      input logic d, input logic l);
    q.push_back('{pin: AW'(p), vec: v, mode: m, dest: d, lvl: l});
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, input logic [63:0] exp, input string tag);
    @(negedge clk); addr = AW'(a); #1;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: entry %0d got %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk); eoi = 1; eoi_vec = v;
    @(negedge clk); eoi = 0;
  endtask

  task automatic settle(input int n, input string tag);
    repeat (n) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: pending deliveries got %0d expected 0", tag, q.size());
      q.delete();
    end
  endtask

  task automatic chk_bit(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: dlv got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    cur_tag = "R1";
    rd(0, 64'h1_0000, "R1");
    rd(NP - 1, 64'h1_0000, "R1");
    settle(3, "R1");

    // R3 / R2 edge pin, fields carried
    cur_tag = "R3";
    wr(3, mk(8'h31, 3'b101, 1'b1, 1'b0, 1'b0, 1'b0));
    push(3, 8'h31, 3'b101, 1'b1, 1'b0);
    @(negedge clk); pins[3] = 1;
    settle(6, "R3");
    @(negedge clk); pins[3] = 0;
    settle(2, "R2");

    // R11 active-low level pin
    cur_tag = "R11";
    push(5, 8'h52, 3'b000, 1'b0, 1'b1);
    wr(5, mk(8'h52, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0));
    settle(4, "R11");
    @(negedge clk); pins[5] = 1;
    send_eoi(8'h52);
    settle(4, "R11");
    rd(5, mk(8'h52, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0), "R11");
    push(5, 8'h52, 3'b000, 1'b0, 1'b1);
    @(negedge clk); pins[5] = 0;
    settle(4, "R11");
    @(negedge clk); pins[5] = 1;
    send_eoi(8'h52);
    settle(2, "R11");

    // R4 level pin sets remote IRR and is not redelivered
    cur_tag = "R4";
    wr(7, mk(8'h47, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0));
    push(7, 8'h47, 3'b001, 1'b0, 1'b1);
    @(negedge clk); pins[7] = 1;
    settle(6, "R4");
    rd(7, mk(8'h47, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0) | RIRR, "R4");

    // R6 non-matching vector, and matching entry with rirr clear
    cur_tag = "R6";
    wr(8, mk(8'h47, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0));
    send_eoi(8'h48);
    settle(4, "R6");
    rd(7, mk(8'h47, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0) | RIRR, "R6");

    // R5 matching EOI with line still active: redelivery
    cur_tag = "R5";
    push(7, 8'h47, 3'b001, 1'b0, 1'b1);
    send_eoi(8'h47);
    settle(4, "R5");
    rd(8, mk(8'h47, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0), "R6");
    rd(7, mk(8'h47, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0) | RIRR, "R5");

    // R7 EOI after line dropped: clear only
    cur_tag = "R7";
    @(negedge clk); pins[7] = 0;
    settle(2, "R7");
    send_eoi(8'h47);
    settle(4, "R7");
    rd(7, mk(8'h47, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0), "R7");

    // R10 remote IRR ignores writes
    cur_tag = "R10";
    wr(7, mk(8'h47, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0) | RIRR);
    rd(7, mk(8'h47, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0), "R10");
    push(7, 8'h47, 3'b001, 1'b0, 1'b1);
    @(negedge clk); pins[7] = 1;
    settle(4, "R10");
    wr(7, mk(8'h47, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0));
    rd(7, mk(8'h47, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0) | RIRR, "R10");
    @(negedge clk); pins[7] = 0;
    send_eoi(8'h47);
    settle(3, "R10");

    // R8 masked edge request held, delivered on unmask
    cur_tag = "R8";
    wr(10, mk(8'h0A, 3'b010, 1'b0, 1'b0, 1'b0, 1'b1));
    @(negedge clk); pins[10] = 1;
    settle(5, "R8");
    push(10, 8'h0A, 3'b010, 1'b0, 1'b0);
    wr(10, mk(8'h0A, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0));
    settle(4, "R8");
    @(negedge clk); pins[10] = 0;

    // R9 simultaneous requests, ascending order
    cur_tag = "R9";
    wr(20, mk(8'h34, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0));
    wr(12, mk(8'h2C, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(2,  mk(8'h22, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0));
    push(2, 8'h22, 3'b000, 1'b1, 1'b0);
    push(12, 8'h2C, 3'b011, 1'b0, 1'b0);
    push(20, 8'h34, 3'b100, 1'b1, 1'b0);
    @(negedge clk); pins[2] = 1; pins[12] = 1; pins[20] = 1;
    @(negedge clk); chk_bit(dlv, 1'b0, "R9");
    @(negedge clk); chk_bit(dlv, 1'b1, "R9");
    @(negedge clk); chk_bit(dlv, 1'b1, "R9");
    @(negedge clk); chk_bit(dlv, 1'b1, "R9");
    settle(3, "R9");
    @(negedge clk); pins[2] = 0; pins[12] = 0; pins[20] = 0;

    // R12 two-edge latency
    cur_tag = "R12";
    wr(4, mk(8'h64, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0));
    push(4, 8'h64, 3'b001, 1'b0, 1'b0);
    @(negedge clk); pins[4] = 1;
    @(negedge clk); chk_bit(dlv, 1'b0, "R12");
    @(negedge clk); chk_bit(dlv, 1'b1, "R12");
    settle(3, "R12");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule